// File: doc/BRIEF.md
# Privileged Access-Never Permission Filter

This block sits beside the permission decoder of an address-translation cache. It takes the verdict that decoder has already reached for one access and decides whether an extra rule overrides it. The rule applies when a status bit is set that forbids privileged code from touching user memory. Under that rule, a data access made from privilege level 1 or 2 to a page that level 0 may also reach is refused. The filter also reports that the refusal came from this rule, so that fault reporting can tell it apart from an ordinary permission fault.

The rule has narrow exemptions:

- Instruction fetches are never refused by it.
- Cache maintenance operations are exempt, except the one that zeroes a whole block, which is treated like a data write.
- Unprivileged load/store variants are treated as level-0 accesses and skip the rule.
- When the feature-present input is low, the regular verdict passes through untouched.

The decision is registered. Each valid request produces, one cycle later, a one-cycle response pulse that carries the grant and the access-never flag.

Top module: `access_never_filter`

## Requirements
- R1: With `featureOn`=1, `neverBit`=1, `unprivOp`=0, `apField[0]`=1, `privLevel` equal to 1 or 2, and `accessKind` equal to read (1) or write (2), the response has grant 0 and `rspNeverDeny` 1.
- R2: When `apField[0]`=0, meaning the page is not reachable from level 0, the response grant equals `baseGrant` and `rspNeverDeny` is 0.
- R3: An instruction fetch (`accessKind`=0) is never refused by the rule. Its grant equals `baseGrant` and its flag is 0.
- R4: Cache maintenance (`accessKind`=3) and the codes 5 to 7 are exempt and pass `baseGrant` through. Block zeroing (`accessKind`=4) is checked exactly like a write.
- R5: With `featureOn`=0, the grant equals `baseGrant` and the flag is 0, whatever the other inputs hold.
- R6: Accesses at `privLevel` 0 or 3 are never refused by the rule.
- R7: A refusal by the rule forces grant 0 even when `baseGrant`=1. When the rule does not refuse, the grant equals `baseGrant`.
- R8: With `unprivOp`=1, the rule is bypassed and the grant equals `baseGrant`.
- R9: `rspValid` is 1 in exactly the cycle after a cycle with `reqValid`=1, and its grant and flag belong to that request.
- R10: `rspNeverDeny` is 1 only together with `rspValid`=1 and `rspGrant`=0.
- R11: While `rspValid` is 0, including during and after reset, `rspGrant` and `rspNeverDeny` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| privLevel | input | 2 | Current privilege level, 0 to 3 |
| neverBit | input | 1 | Status bit that forbids privileged access to user pages |
| featureOn | input | 1 | Feature-present flag |
| unprivOp | input | 1 | Access is an unprivileged load/store variant |
| apField | input | 2 | Page access-permission field; bit 0 marks the page as level-0 accessible |
| baseGrant | input | 1 | Verdict of the regular permission decoder |
| accessKind | input | 3 | 0 fetch, 1 read, 2 write, 3 maintenance, 4 block zero |
| rspValid | output | 1 | Response pulse, one cycle after a request |
| rspGrant | output | 1 | Final grant (1) or deny (0) |
| rspNeverDeny | output | 1 | Denial caused by the access-never rule |

## Verification
Every result is due exactly one clock edge after its request: a request is driven on a falling edge, captured on the next rising edge, and checked on the falling edge that follows. The bench keeps a queue of expected responses, one entry pushed per driven cycle and one popped per check, so every comparison lines up with that single-edge latency. Idle cycles push an all-zero entry, which checks the idle outputs in the same way. The stimulus sweeps every combination of level, kind, permission field, status bit, feature flag, unprivileged marker and base verdict, with idle gaps mixed in.

// File: rtl/anf_pkg.sv
package anf_pkg;
  localparam int LEVEL_W = 2;
  localparam int KIND_W  = 3;
  localparam int AP_W    = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_FETCH = 3'd0,
    KIND_READ  = 3'd1,
    KIND_WRITE = 3'd2,
    KIND_MAINT = 3'd3,
    KIND_ZERO  = 3'd4
  } access_kind_e;

  typedef struct packed {
    logic capture;
    logic idle;
  } ctrl_strobe_t;
endpackage

// File: rtl/anf_ctrl.sv
module anf_ctrl
  import anf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output ctrl_strobe_t strobe,
  output logic         rspValid
);
  always_comb begin
    strobe.capture = reqValid;
    strobe.idle    = ~reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strobe.capture;
  end
endmodule

// File: rtl/anf_datapath.sv
module anf_datapath
  import anf_pkg::*;
#(
  parameter int               LVL_W          = LEVEL_W,
  parameter int               KND_W          = KIND_W,
  parameter int               APW            = AP_W,
  parameter int               USER_AP_BIT    = 0,
  parameter logic [(1<<LVL_W)-1:0] GUARDED_LEVELS = 4'b0110
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobe,
  input  logic [LVL_W-1:0] privLevel,
  input  logic             neverBit,
  input  logic             featureOn,
  input  logic             unprivOp,
  input  logic [APW-1:0]   apField,
  input  logic             baseGrant,
  input  logic [KND_W-1:0] accessKind,
  output logic             rspGrant,
  output logic             rspNeverDeny
);
  localparam int NUM_LEVELS = 1 << LVL_W;

  logic [NUM_LEVELS-1:0] levelHit;
  logic levelGuarded;
  logic kindChecked;
  logic userPage;
  logic neverDeny;
  logic finalGrant;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
    if (GUARDED_LEVELS[l]) begin : g_on
      assign levelHit[l] = (privLevel == LVL_W'(l));
    end else begin : g_off
      assign levelHit[l] = 1'b0;
    end
  end

  assign levelGuarded = |levelHit;
  assign userPage     = apField[USER_AP_BIT];

  always_comb begin
    unique case (accessKind)
      KIND_READ, KIND_WRITE, KIND_ZERO: kindChecked = 1'b1;
      default:                          kindChecked = 1'b0;
    endcase
  end

  always_comb begin
    neverDeny  = featureOn & neverBit & ~unprivOp & levelGuarded & userPage & kindChecked;
    finalGrant = neverDeny ? 1'b0 : baseGrant;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspGrant     <= 1'b0;
      rspNeverDeny <= 1'b0;
    end else if (strobe.capture) begin
      rspGrant     <= finalGrant;
      rspNeverDeny <= neverDeny;
    end else if (strobe.idle) begin
      rspGrant     <= 1'b0;
      rspNeverDeny <= 1'b0;
    end
  end
endmodule

// File: rtl/access_never_filter.sv
module access_never_filter
  import anf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [LEVEL_W-1:0] privLevel,
  input  logic               neverBit,
  input  logic               featureOn,
  input  logic               unprivOp,
  input  logic [AP_W-1:0]    apField,
  input  logic               baseGrant,
  input  logic [KIND_W-1:0]  accessKind,
  output logic               rspValid,
  output logic               rspGrant,
  output logic               rspNeverDeny
);
  ctrl_strobe_t strobe;

  anf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  anf_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .privLevel    (privLevel),
    .neverBit     (neverBit),
    .featureOn    (featureOn),
    .unprivOp     (unprivOp),
    .apField      (apField),
    .baseGrant    (baseGrant),
    .accessKind   (accessKind),
    .rspGrant     (rspGrant),
    .rspNeverDeny (rspNeverDeny)
  );
endmodule

// File: rtl/anf_checker.sv
module anf_checker
  import anf_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [LEVEL_W-1:0] privLevel,
  input logic               neverBit,
  input logic               featureOn,
  input logic               unprivOp,
  input logic [AP_W-1:0]    apField,
  input logic               baseGrant,
  input logic [KIND_W-1:0]  accessKind,
  input logic               rspValid,
  input logic               rspGrant,
  input logic               rspNeverDeny
);
  assert_deny_user_page_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && featureOn && neverBit && !unprivOp && apField[0] &&
     (privLevel == 2'd1 || privLevel == 2'd2) &&
     (accessKind == 3'd1 || accessKind == 3'd2 || accessKind == 3'd4))
    |=> (!rspGrant && rspNeverDeny));

  assert_fetch_exempt_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accessKind == 3'd0) |=> (!rspNeverDeny && rspGrant == $past(baseGrant)));

  assert_feature_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !featureOn) |=> (!rspNeverDeny && rspGrant == $past(baseGrant)));

  assert_outer_levels_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (privLevel == 2'd0 || privLevel == 2'd3)) |=> !rspNeverDeny);

  assert_unpriv_bypass_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && unprivOp) |=> (!rspNeverDeny && rspGrant == $past(baseGrant)));

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_flag_with_deny_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspNeverDeny |-> (rspValid && !rspGrant));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspGrant && !rspNeverDeny));
endmodule

bind access_never_filter anf_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .privLevel    (privLevel),
  .neverBit     (neverBit),
  .featureOn    (featureOn),
  .unprivOp     (unprivOp),
  .apField      (apField),
  .baseGrant    (baseGrant),
  .accessKind   (accessKind),
  .rspValid     (rspValid),
  .rspGrant     (rspGrant),
  .rspNeverDeny (rspNeverDeny)
);

// File: tb/access_never_filter_test.sv
module access_never_filter_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN, reqValid, neverBit, featureOn, unprivOp, baseGrant;
  logic [1:0] privLevel, apField;
  logic [2:0] accessKind;
  logic       rspValid, rspGrant, rspNeverDeny;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [2:0] expQ[$];
  string      tagQ[$];

  access_never_filter uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .privLevel(privLevel),
    .neverBit(neverBit), .featureOn(featureOn), .unprivOp(unprivOp),
    .apField(apField), .baseGrant(baseGrant), .accessKind(accessKind),
    .rspValid(rspValid), .rspGrant(rspGrant), .rspNeverDeny(rspNeverDeny)
  );

  // Reference model: returns {grant, neverFlag} and the requirement it exercises
  function automatic logic [1:0] refModel(input logic [1:0] lvl, input logic nb,
      input logic fo, input logic up, input logic [1:0] ap, input logic bg,
      input logic [2:0] kind, output string tag);
    if (!fo)                       begin tag = "R5"; return {bg, 1'b0}; end
    if (up)                        begin tag = "R8"; return {bg, 1'b0}; end
    if (lvl == 0 || lvl == 3)      begin tag = "R6"; return {bg, 1'b0}; end
    if (kind == 0)                 begin tag = "R3"; return {bg, 1'b0}; end
    if (kind == 3 || kind > 4)     begin tag = "R4"; return {bg, 1'b0}; end
    if (!ap[0])                    begin tag = "R2"; return {bg, 1'b0}; end
    if (!nb)                       begin tag = "R7"; return {bg, 1'b0}; end
    if (kind == 4)                 begin tag = "R4"; return 2'b01; end
    tag = bg ? "R7" : "R1";
    return 2'b01;
  endfunction

  task automatic compareHead();
    logic [2:0] e;
    string t;
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    checks++;
    if ({rspValid, rspGrant, rspNeverDeny} !== e) begin
      fails++;
      $display("FAIL %s: got v/g/f=%b%b%b expected %b", t, rspValid, rspGrant, rspNeverDeny, e);
    end
    checks++;
    if (rspNeverDeny && (rspGrant || !rspValid)) begin
      fails++;
      $display("FAIL R10: flag=%b with grant=%b valid=%b expected grant=0 valid=1",
               rspNeverDeny, rspGrant, rspValid);
    end
  endtask

  task automatic cycle(input logic v, input logic [1:0] lvl, input logic nb,
      input logic fo, input logic up, input logic [1:0] ap, input logic bg,
      input logic [2:0] kind);
    logic [1:0] r;
    string t;
    @(negedge clk);
    compareHead();
    reqValid = v; privLevel = lvl; neverBit = nb; featureOn = fo;
    unprivOp = up; apField = ap; baseGrant = bg; accessKind = kind;
    r = refModel(lvl, nb, fo, up, ap, bg, kind, t);
    if (v) begin expQ.push_back({1'b1, r}); tagQ.push_back({t, "/R9"}); end
    else   begin expQ.push_back(3'b000);    tagQ.push_back("R11"); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9: watchdog expired, got no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b1; privLevel = 2'd1; neverBit = 1'b1; featureOn = 1'b1;
    unprivOp = 1'b0; apField = 2'b01; baseGrant = 1'b1; accessKind = 3'd1;
    repeat (3) @(negedge clk);
    checks++;
    if ({rspValid, rspGrant, rspNeverDeny} !== 3'b000) begin
      fails++;
      $display("FAIL R11: reset outputs %b%b%b expected 000", rspValid, rspGrant, rspNeverDeny);
    end
    reqValid = 1'b0;
    @(negedge clk); rstN = 1'b1;

    // Directed cases
    cycle(1, 2'd1, 1, 1, 0, 2'b01, 1, 3'd1); // R1 read at level 1, R7 base grant overridden
    cycle(1, 2'd2, 1, 1, 0, 2'b11, 0, 3'd2); // R1 write at level 2
    cycle(1, 2'd1, 1, 1, 0, 2'b10, 1, 3'd1); // R2 page not user-accessible
    cycle(1, 2'd1, 1, 1, 0, 2'b01, 1, 3'd0); // R3 fetch
    cycle(1, 2'd1, 1, 1, 0, 2'b01, 1, 3'd3); // R4 maintenance exempt
    cycle(1, 2'd2, 1, 1, 0, 2'b01, 1, 3'd4); // R4 block zero checked
    cycle(1, 2'd1, 1, 0, 0, 2'b01, 1, 3'd2); // R5 feature off
    cycle(1, 2'd0, 1, 1, 0, 2'b01, 1, 3'd1); // R6 level 0
    cycle(1, 2'd3, 1, 1, 0, 2'b01, 1, 3'd2); // R6 level 3
    cycle(1, 2'd1, 0, 1, 0, 2'b01, 0, 3'd1); // R7 bit clear, base deny kept
    cycle(1, 2'd1, 1, 1, 1, 2'b01, 1, 3'd1); // R8 unprivileged variant
    cycle(0, 2'd1, 1, 1, 0, 2'b01, 1, 3'd1); // R11 idle with denying inputs
    cycle(1, 2'd1, 1, 1, 0, 2'b01, 1, 3'd2); // R9 back-to-back
    cycle(1, 2'd2, 1, 1, 0, 2'b01, 1, 3'd4);

    // Exhaustive sweep with idle gaps
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] c;
      c = 12'(i);
      cycle((i % 5) != 3, c[1:0], c[2], c[3], c[4], c[6:5], c[7], c[10:8]);
    end
    cycle(0, 2'd0, 0, 0, 0, 2'b00, 0, 3'd0);
    @(negedge clk);
    compareHead();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule